// File: doc/BRIEF.md
# PCM Frame Synchronizer with Bit Offset

This block locks a serial PCM time-slot frame to an external framing pulse. A fast system clock oversamples the PCM bit clock and the framing input through two-flop synchronizers. Each edge of the bit clock becomes a one-cycle enable in the system domain. The framing input is sampled on a configurable bit-clock edge. A sampled low-to-high change restarts a free-running frame reference counter. Two bit numbers are derived from that counter, one for the receive direction (`dn_bit`) and one for the transmit direction (`up_bit`). Each has its own offset of up to a full frame.

Transmit bytes enter through a valid/ready stream. `tx_ready` is high for exactly one system cycle, at the launch of bit position 0 of each transmit slot. The byte is taken in that cycle if `tx_valid` is also high. Otherwise the slot carries all ones and the offered byte waits for the next slot. Received bytes leave as a one-cycle `rx_valid` pulse carrying the byte and its slot index. The receive side has no back-pressure: the consumer must take `rx_data` in the cycle `rx_valid` is high. The launch edge and the capture edge are chosen independently. `FRAME_BITS` must be a multiple of 8 and at least 16. The bit clock must stay high and low for at least four system cycles each.

Top module: `pcm_frame_sync`

## Requirements
- R1: The framing input is sampled on every falling `pcm_clk` edge when `cfg_fs_rise` is 0, and on every rising edge when it is 1. A framing pulse that lies wholly between two edges of the selected kind has no effect.
- R2: A frame restarts only when the sampled framing level goes from 0 to 1. A framing input held high for many bits does not restart the frame again, and a new restart needs at least one low sample first.
- R3: The reference bit counter advances by one on every rising `pcm_clk` edge and wraps modulo `FRAME_BITS`. After a qualifying sample it takes the value 0 for the bit period that begins at the first rising edge at or after that sample. `dn_bit` equals (reference − `cfg_dn_offset` mod `FRAME_BITS`) mod `FRAME_BITS`.
- R4: `up_bit` equals (reference − `cfg_up_offset` mod `FRAME_BITS`) mod `FRAME_BITS`, independent of the downstream offset. Both offsets are 10 bits wide, and any value ≥ `FRAME_BITS` is reduced modulo `FRAME_BITS`.
- R5: `synced` is 0 from reset until the first frame restart, and 1 from then on.
- R6: `dn_sof` (`up_sof`) gives exactly one single-cycle pulse in each bit period in which `dn_bit` (`up_bit`) is 0, and no pulse in other bit periods.
- R7: When `cfg_tx_rise` is 1, `pcm_txd` changes only after rising `pcm_clk` edges. When it is 0, `pcm_txd` changes after the falling edge that follows the rising edge opening the bit period.
- R8: Bit position p = `up_bit` mod 8 carries bit 7−p of the current slot byte, so bytes go MSB first. At p = 0, `tx_ready` pulses. The byte on `tx_data` is used if `tx_valid` is high, and 8'hFF is used otherwise.
- R9: When `cfg_rx_rise` is 0, `pcm_rxd` is captured on the falling edge inside the bit period. When it is 1, it is captured on the next rising edge. The bit is credited to the bit period it was driven in, and a finished byte is reported after the capturing edge.
- R10: The bit captured for position p = `dn_bit` mod 8 lands in byte bit 7−p. After position 7 is captured, `rx_valid` pulses for one cycle with `rx_data` and `rx_slot` = `dn_bit` / 8.
- R11: During and right after reset: `synced` = 0, `pcm_txd` = 1, `rx_valid` = 0, and the reference counter is 0. So `dn_bit` = (0 − `cfg_dn_offset`) mod `FRAME_BITS`, and `up_bit` is the same with its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_clk | input | 1 | PCM bit clock (asynchronous) |
| pcm_fs | input | 1 | Framing pulse (asynchronous) |
| pcm_rxd | input | 1 | Serial receive data |
| cfg_fs_rise | input | 1 | Framing sample edge: 0 falling, 1 rising |
| cfg_tx_rise | input | 1 | Launch edge: 1 rising, 0 following falling |
| cfg_rx_rise | input | 1 | Capture edge: 0 falling, 1 following rising |
| cfg_dn_offset | input | OFF_W | Receive-direction bit offset |
| cfg_up_offset | input | OFF_W | Transmit-direction bit offset |
| tx_data | input | 8 | Byte for the next transmit slot |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Slot start; byte taken when `tx_valid` is high |
| pcm_txd | output | 1 | Serial transmit data |
| rx_data | output | 8 | Received slot byte |
| rx_slot | output | SLOT_W | Slot index of `rx_data` |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` / `rx_slot` |
| dn_bit | output | CNT_W | Receive-direction bit number |
| up_bit | output | CNT_W | Transmit-direction bit number |
| dn_sof | output | 1 | Receive-direction frame-start strobe |
| up_sof | output | 1 | Transmit-direction frame-start strobe |
| synced | output | 1 | A frame restart has occurred since reset |

## Verification
The hardest case to reach is a framing pulse that only one of the two sampling edges can see. With well-behaved pulses, both sampling modes realign the frame to the same bit, so mode-specific behaviour stays hidden. The stimulus therefore raises the framing input only during the low half of one bit period and drops it inside the next high half. Rising-edge sampling must restart the frame and falling-edge sampling must ignore it. The same sweep, over all eight edge-polarity combinations with offsets at and beyond the frame length, also holds a long high framing pulse and cuts off transmit data for a few slots.

// File: rtl/pcm_sync_pkg.sv
package pcm_sync_pkg;

  localparam int SLOT_BITS = 8;

  // Bit number seen by one direction: reference position moved back by the
  // direction's offset, everything modulo the frame length.
  function automatic int unsigned shifted_pos(input int unsigned ref_pos,
                                              input int unsigned offset,
                                              input int unsigned frame_len);
    int unsigned m;
    m = offset % frame_len;
    return (ref_pos + frame_len - m) % frame_len;
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int NUM    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] d_async,
  output logic [NUM-1:0] d_sync
);

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d_async[g]};
    end
    assign d_sync[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_sync_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int OFF_W      = 10,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_s,
  input  logic             fs_s,
  input  logic             cfg_fs_rise,
  input  logic [OFF_W-1:0] cfg_dn_offset,
  input  logic [OFF_W-1:0] cfg_up_offset,
  output logic             edge_r,
  output logic             edge_f,
  output logic [CNT_W-1:0] dn_bit,
  output logic [CNT_W-1:0] up_bit,
  output logic [CNT_W-1:0] dn_prev,
  output logic             dn_sof,
  output logic             up_sof,
  output logic             synced
);

  logic             dclk_q;
  logic             rise, fall;
  logic             samp_en, fs_last, fs_up, pend, start;
  logic [CNT_W-1:0] ref_q;
  logic [OFF_W-1:0] off_arr [2];
  logic [CNT_W-1:0] pos_arr [2];
  logic             sof_arr [2];

  assign rise    = dclk_s & ~dclk_q;
  assign fall    = ~dclk_s & dclk_q;
  assign samp_en = cfg_fs_rise ? rise : fall;
  assign fs_up   = samp_en & fs_s & ~fs_last;
  assign start   = rise & (pend | fs_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      fs_last <= 1'b0;
      pend    <= 1'b0;
      ref_q   <= '0;
      synced  <= 1'b0;
      dn_prev <= '0;
      edge_r  <= 1'b0;
      edge_f  <= 1'b0;
    end else begin
      dclk_q <= dclk_s;
      edge_r <= rise;
      edge_f <= fall;
      if (samp_en) fs_last <= fs_s;
      if (rise)       pend <= 1'b0;
      else if (fs_up) pend <= 1'b1;
      if (rise) begin
        dn_prev <= pos_arr[0];
        if (start)                            ref_q <= '0;
        else if (ref_q == CNT_W'(FRAME_BITS - 1)) ref_q <= '0;
        else                                  ref_q <= ref_q + 1'b1;
      end
      if (start) synced <= 1'b1;
    end
  end

  assign off_arr[0] = cfg_dn_offset;
  assign off_arr[1] = cfg_up_offset;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign pos_arr[d] = CNT_W'(shifted_pos(32'(ref_q), 32'(off_arr[d]),
                                           32'(FRAME_BITS)));
    assign sof_arr[d] = edge_r & (pos_arr[d] == '0);
  end

  assign dn_bit = pos_arr[0];
  assign up_bit = pos_arr[1];
  assign dn_sof = sof_arr[0];
  assign up_sof = sof_arr[1];

  assert_synced_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);

  assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dn_bit) < FRAME_BITS) && (32'(up_bit) < FRAME_BITS));

  assert_sof_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_sof || up_sof) |=> !(dn_sof || up_sof));

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_r,
  input  logic                 edge_f,
  input  logic                 cfg_tx_rise,
  input  logic [CNT_W-1:0]     up_bit,
  input  logic [SLOT_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 pcm_txd
);

  logic                 launch, first;
  logic [2:0]           pos;
  logic [SLOT_BITS-1:0] sr, load;

  assign launch   = cfg_tx_rise ? edge_r : edge_f;
  assign pos      = up_bit[2:0];
  assign first    = (pos == 3'd0);
  assign tx_ready = launch & first;
  assign load     = tx_valid ? tx_data : {SLOT_BITS{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= {SLOT_BITS{1'b1}};
      pcm_txd <= 1'b1;
    end else if (launch) begin
      if (first) begin
        sr      <= load;
        pcm_txd <= load[SLOT_BITS-1];
      end else begin
        pcm_txd <= sr[3'd7 - pos];
      end
    end
  end

  assert_txd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(pcm_txd));

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_sync_pkg::*;
#(
  parameter int CNT_W  = 8,
  localparam int SLOT_W = CNT_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_r,
  input  logic                 edge_f,
  input  logic                 cfg_rx_rise,
  input  logic [CNT_W-1:0]     dn_bit,
  input  logic [CNT_W-1:0]     dn_prev,
  input  logic                 rxd_s,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic [SLOT_W-1:0]    rx_slot,
  output logic                 rx_valid
);

  logic                 fall_seen, cap;
  logic [CNT_W-1:0]     idx;
  logic [2:0]           pos;
  logic [SLOT_BITS-1:0] sr;

  assign cap = cfg_rx_rise ? (edge_r & fall_seen) : edge_f;
  assign idx = cfg_rx_rise ? dn_prev : dn_bit;
  assign pos = idx[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fall_seen <= 1'b0;
      sr        <= '0;
      rx_data   <= '0;
      rx_slot   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (edge_f)      fall_seen <= 1'b1;
      else if (edge_r) fall_seen <= 1'b0;
      if (cap) begin
        sr[3'd7 - pos] <= rxd_s;
        if (pos == 3'd7) begin
          rx_valid <= 1'b1;
          rx_data  <= {sr[SLOT_BITS-1:1], rxd_s};
          rx_slot  <= idx[CNT_W-1:3];
        end
      end
    end
  end

  assert_rx_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/pcm_frame_sync.sv
module pcm_frame_sync
  import pcm_sync_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int OFF_W      = 10,
  localparam int CNT_W     = $clog2(FRAME_BITS),
  localparam int SLOT_W    = CNT_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pcm_clk,
  input  logic                 pcm_fs,
  input  logic                 pcm_rxd,
  input  logic                 cfg_fs_rise,
  input  logic                 cfg_tx_rise,
  input  logic                 cfg_rx_rise,
  input  logic [OFF_W-1:0]     cfg_dn_offset,
  input  logic [OFF_W-1:0]     cfg_up_offset,
  input  logic [SLOT_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 pcm_txd,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic [SLOT_W-1:0]    rx_slot,
  output logic                 rx_valid,
  output logic [CNT_W-1:0]     dn_bit,
  output logic [CNT_W-1:0]     up_bit,
  output logic                 dn_sof,
  output logic                 up_sof,
  output logic                 synced
);

  logic [2:0]       in_s;
  logic             edge_r, edge_f;
  logic [CNT_W-1:0] dn_prev;

  pcm_in_sync #(.NUM(3), .STAGES(2)) u_in_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({pcm_rxd, pcm_fs, pcm_clk}),
    .d_sync  (in_s)
  );

  pcm_frame_timer #(.FRAME_BITS(FRAME_BITS), .OFF_W(OFF_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .dclk_s        (in_s[0]),
    .fs_s          (in_s[1]),
    .cfg_fs_rise   (cfg_fs_rise),
    .cfg_dn_offset (cfg_dn_offset),
    .cfg_up_offset (cfg_up_offset),
    .edge_r        (edge_r),
    .edge_f        (edge_f),
    .dn_bit        (dn_bit),
    .up_bit        (up_bit),
    .dn_prev       (dn_prev),
    .dn_sof        (dn_sof),
    .up_sof        (up_sof),
    .synced        (synced)
  );

  pcm_tx_slot #(.CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_r      (edge_r),
    .edge_f      (edge_f),
    .cfg_tx_rise (cfg_tx_rise),
    .up_bit      (up_bit),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .pcm_txd     (pcm_txd)
  );

  pcm_rx_slot #(.CNT_W(CNT_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_r      (edge_r),
    .edge_f      (edge_f),
    .cfg_rx_rise (cfg_rx_rise),
    .dn_bit      (dn_bit),
    .dn_prev     (dn_prev),
    .rxd_s       (in_s[2]),
    .rx_data     (rx_data),
    .rx_slot     (rx_slot),
    .rx_valid    (rx_valid)
  );

endmodule

// File: tb/test_pcm_frame_sync.sv
module test_pcm_frame_sync;

  localparam int CLK_NS = 10;
  localparam int N      = 32;
  localparam int OFF_W  = 10;
  localparam int CNT_W  = $clog2(N);
  localparam int SLOT_W = CNT_W - 3;
  localparam int NPER   = 100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pcm_clk = 1'b0, pcm_fs = 1'b0, pcm_rxd = 1'b0;
  logic              cfg_fs_rise = 1'b0, cfg_tx_rise = 1'b0, cfg_rx_rise = 1'b0;
  logic [OFF_W-1:0]  cfg_dn_offset = '0, cfg_up_offset = '0;
  logic [7:0]        tx_data;
  logic              tx_valid = 1'b1;
  logic              tx_ready, pcm_txd, rx_valid, dn_sof, up_sof, synced;
  logic [7:0]        rx_data;
  logic [SLOT_W-1:0] rx_slot;
  logic [CNT_W-1:0]  dn_bit, up_bit;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int dn_cnt = 0, up_cnt = 0, rx_cnt = 0;
  int rx_d = 0, rx_s = 0;

  always #(CLK_NS / 2) clk = ~clk;
  assign tx_data = seq[7:0];

  pcm_frame_sync #(.FRAME_BITS(N), .OFF_W(OFF_W)) i_pcm_frame_sync (
    .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .pcm_fs(pcm_fs),
    .pcm_rxd(pcm_rxd), .cfg_fs_rise(cfg_fs_rise), .cfg_tx_rise(cfg_tx_rise),
    .cfg_rx_rise(cfg_rx_rise), .cfg_dn_offset(cfg_dn_offset),
    .cfg_up_offset(cfg_up_offset), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .pcm_txd(pcm_txd), .rx_data(rx_data),
    .rx_slot(rx_slot), .rx_valid(rx_valid), .dn_bit(dn_bit), .up_bit(up_bit),
    .dn_sof(dn_sof), .up_sof(up_sof), .synced(synced)
  );

  always @(posedge clk) begin
    if (dn_sof) dn_cnt++;
    if (up_sof) up_cnt++;
    if (rx_valid) begin
      rx_cnt++;
      rx_d = int'(rx_data);
      rx_s = int'(rx_slot);
    end
    if (tx_valid && tx_ready) seq++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fs_hi(input int p);
    return (p >= 10 && p <= 14) || (p >= 70 && p <= 72);
  endfunction
  function automatic bit fs_lo(input int p);
    return (p >= 10 && p <= 14) || (p >= 70 && p <= 72) || (p == 40);
  endfunction
  function automatic bit rx_bit(input int p);
    return ((p * 13 + 5) % 7) < 3;
  endfunction
  function automatic bit tx_on(input int p);
    return !(p >= 50 && p <= 60);
  endfunction

  task automatic run_cfg(input int cfg);
    int dn_off, up_off, refp, dn, up, pos, rpos, seq_m;
    bit last, s_in, start, msync, txd_prev, bit_now, pend_ev, ev;
    bit [7:0] tx_byte, rxm;
    int pend_d, pend_s, ev_d, ev_s;
    string tag;
    dn_off = cfg * 7 + (cfg[0] ? 64 : 0);
    up_off = (cfg == 5) ? 1023 : (31 - cfg * 3 + (cfg[1] ? 32 : 0));
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fs_rise = cfg[0];
    cfg_tx_rise = cfg[1];
    cfg_rx_rise = cfg[2];
    cfg_dn_offset = OFF_W'(dn_off);
    cfg_up_offset = OFF_W'(up_off);
    pcm_clk = 1'b0; pcm_fs = 1'b0; pcm_rxd = 1'b0; tx_valid = 1'b1;
    seq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(synced == 1'b0, "R11 synced", int'(synced), 0);
    chk(pcm_txd == 1'b1, "R11 txd", int'(pcm_txd), 1);
    chk(rx_valid == 1'b0, "R11 rx_valid", int'(rx_valid), 0);
    chk(int'(dn_bit) == (N - dn_off % N) % N, "R11 dn_bit", int'(dn_bit), (N - dn_off % N) % N);
    chk(int'(up_bit) == (N - up_off % N) % N, "R11 up_bit", int'(up_bit), (N - up_off % N) % N);
    refp = 0; last = 1'b0; msync = 1'b0; txd_prev = 1'b1; seq_m = 0;
    tx_byte = 8'hFF; rxm = 8'h00; pend_ev = 1'b0; pend_d = 0; pend_s = 0;
    for (int p = 0; p < NPER; p++) begin
      s_in = (p == 0) ? 1'b0 : (cfg[0] ? fs_lo(p - 1) : fs_hi(p - 1));
      start = s_in && !last;
      last = s_in;
      refp = start ? 0 : (refp + 1) % N;
      if (start) msync = 1'b1;
      dn = (refp + N - dn_off % N) % N;
      up = (refp + N - up_off % N) % N;
      pos = up % 8;
      if (pos == 0) begin
        if (tx_on(p)) begin tx_byte = 8'(seq_m); seq_m++; end
        else tx_byte = 8'hFF;
      end
      bit_now = tx_byte[7 - pos];
      // high half of bit period p
      @(negedge clk);
      pcm_clk = 1'b1;
      tx_valid = tx_on(p);
      dn_cnt = 0; up_cnt = 0; rx_cnt = 0;
      repeat (3) @(negedge clk);
      pcm_fs = fs_hi(p);
      pcm_rxd = rx_bit(p);
      repeat (2) @(negedge clk);
      // R7: value on the line before the falling edge
      chk(pcm_txd == (cfg[1] ? bit_now : txd_prev), "R7 txd high half",
          int'(pcm_txd), int'(cfg[1] ? bit_now : txd_prev));
      chk(dn_cnt == (dn == 0 ? 1 : 0), "R6 dn_sof", dn_cnt, (dn == 0 ? 1 : 0));
      chk(up_cnt == (up == 0 ? 1 : 0), "R6 up_sof", up_cnt, (up == 0 ? 1 : 0));
      if (cfg[2]) begin
        chk(rx_cnt == (pend_ev ? 1 : 0), "R9 rx on rising", rx_cnt, (pend_ev ? 1 : 0));
        if (pend_ev && rx_cnt == 1) begin
          chk(rx_d == pend_d, "R10 rx_data", rx_d, pend_d);
          chk(rx_s == pend_s, "R10 rx_slot", rx_s, pend_s);
        end
      end else begin
        chk(rx_cnt == 0, "R9 no rx in high half", rx_cnt, 0);
      end
      // low half of bit period p
      @(negedge clk);
      pcm_clk = 1'b0;
      rx_cnt = 0;
      repeat (3) @(negedge clk);
      pcm_fs = fs_lo(p);
      repeat (2) @(negedge clk);
      chk(pcm_txd == bit_now, "R8 txd slot bit", int'(pcm_txd), int'(bit_now));
      if (p == 41) tag = "R1 dn_bit after half-period pulse";
      else if (p >= 11 && p <= 20) tag = "R2 dn_bit during long pulse";
      else tag = "R3 dn_bit";
      chk(int'(dn_bit) == dn, tag, int'(dn_bit), dn);
      chk(int'(up_bit) == up, "R4 up_bit", int'(up_bit), up);
      chk(synced == msync, "R5 synced", int'(synced), int'(msync));
      rpos = dn % 8;
      rxm[7 - rpos] = rx_bit(p);
      ev = (rpos == 7);
      ev_d = int'(rxm);
      ev_s = dn / 8;
      if (cfg[2]) begin
        chk(rx_cnt == 0, "R9 no rx in low half", rx_cnt, 0);
        pend_ev = ev; pend_d = ev_d; pend_s = ev_s;
      end else begin
        chk(rx_cnt == (ev ? 1 : 0), "R9 rx on falling", rx_cnt, (ev ? 1 : 0));
        if (ev && rx_cnt == 1) begin
          chk(rx_d == ev_d, "R10 rx_data", rx_d, ev_d);
          chk(rx_s == ev_s, "R10 rx_slot", rx_s, ev_s);
        end
      end
      txd_prev = bit_now;
    end
  endtask

  initial begin
    for (int c = 0; c < 8; c++) run_cfg(c);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule